// File: doc/BRIEF.md
# Decimal Floating Shift-Left Engine

This block widens a decimal floating-point mantissa in place. It works on a memory in which each location holds one BCD digit and a flag bit. The mantissa's units digit stays at a fixed address. Its high-order end moves down to a lower address, so the mantissa grows by the number of new positions. The engine copies the old digits into the top of the new field, going from the highest-order digit to the lowest. It then writes zeros into the new low-order positions, going upward through memory, until it finds a flag bit. What it does at that flag depends on the sign of the fraction.

The engine is started with three operands. The first is the new high-order address of the mantissa. The second is the address of its units digit, which is the same before and after the shift. The third is the old mantissa length. The old mantissa occupies the addresses from units minus length plus one up to units. The flag at the units address gives the sign and is sampled before any write. A flag found during the fill is never cleared. A stray flag inside the widened area therefore ends the fill early, and the mantissa comes out wrong. The engine keeps this behaviour on purpose.

The engine assumes a length of at least 2 and a new field longer than the old one. Fetch, decode and the exponent adjustment are done elsewhere.

Top module: `dshift_engine`

## Requirements
- R1: Out of reset, `busy_o`, `done_o` and `mem_en_o` are low, and the engine makes no memory access while idle.
- R2: For each i from 0 to len-1, the digit of source position (units-len+1+i) is written to address (new_high+i). The copy runs in that order, highest-order digit first.
- R3: A memory word is {flag, digit}, with the flag in bit 4 and the BCD digit in bits 3:0. The source high-order flag is written with the first copied digit. The other copied digits are written with a clear flag.
- R4: The flag on the old high-order source position is removed and its digit is kept. That flag therefore never stops the fill.
- R5: The fill first writes 0 (clear flag) at new_high+len without testing it. After each zero it reads the next address. If that word has no flag, a zero is written there and the fill goes on. If it has a flag, the fill stops.
- R6: If the units flag was clear at start (positive), the flagged word that stops the fill is left unchanged.
- R7: If the units flag was set at start (negative), the stopping address is written with digit 0 and the flag set (5'h10).
- R8: A stray flag above new_high+len stops the fill at that address. Every address above the stopping address keeps its old contents.
- R9: `busy_o` stays high for exactly 3+2*len+2*k cycles, where k is the stopping address minus (new_high+len). `done_o` is high for exactly one cycle: the first cycle after `busy_o` falls.
- R10: A `start_i` pulse while the engine is busy is ignored. The running operation's operands, results and timing do not change.
- R11: The engine makes at most one memory access per cycle, and `mem_we_o` is high only when `mem_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an operation (sampled only while idle) |
| new_high_i | input | AW | Address of the widened mantissa's high-order digit |
| units_i | input | AW | Address of the mantissa's units digit |
| len_i | input | LW | Old mantissa length in digits |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the operation ends |
| mem_en_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write when high, read when low |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | 5 | Write word {flag, digit} |
| mem_rdata_i | input | 5 | Read word, valid the cycle after a read |

## Verification
The bench runs several patterns, and each one separates a different part of the behaviour:
- A clean positive field shows that the fill runs through the old mantissa and stops at the exponent flag.
- A negative field shows that the flagged zero is written at the units position.
- A stray flag in the widened area shows that the fill stops early and the memory above it is left alone.
- A stray flag on the first, untested fill position shows that this flag is overwritten and does not stop the fill.
- A one-digit widening shows the case where the source and destination overlap.
- Random lengths, shifts, signs and stray-flag positions run each case against a model built from the requirements. The model predicts the whole memory image and the exact busy length.
- A restart pulse sent mid-run shows whether a busy engine accepts new operands.

// File: rtl/dshift_pkg.sv
// Package: shared types for the decimal floating shift-left engine.
// Assumes one memory word = one flag bit above a 4-bit BCD digit.
package dshift_pkg;

    typedef struct packed {
        logic       flag;
        logic [3:0] digit;
    } dword_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_SIGN,
        S_RD_SRC,
        S_WR_DST,
        S_CLR_SRC,
        S_FILL_ZERO,
        S_FILL_RD,
        S_FILL_EVAL
    } state_t;

endpackage

// File: rtl/dshift_opnd.sv
// Module: operand holder. Latches the addresses and the length when a start
// is accepted. Captures the sign flag and the old high-order digit from the
// memory read data at fixed points of the sequence.
// Assumes read data arrives one cycle after the read was issued.
module dshift_opnd
    import dshift_pkg::*;
#(
    parameter int AW = 10,
    parameter int LW = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  state_t        state_i,
    input  logic [LW-1:0] idx_i,
    input  logic [AW-1:0] new_high_i,
    input  logic [AW-1:0] units_i,
    input  logic [LW-1:0] len_i,
    input  dword_t        rdata_i,
    output logic [AW-1:0] high_q_o,
    output logic [AW-1:0] units_q_o,
    output logic [LW-1:0] len_q_o,
    output logic          neg_q_o,
    output logic [3:0]    top_digit_q_o
);

    logic first_idx;
    assign first_idx = (idx_i == '0);

    // Capture operands on an accepted start.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            high_q_o  <= '0;
            units_q_o <= '0;
            len_q_o   <= '0;
        end else if (state_i == S_IDLE && start_i) begin
            high_q_o  <= new_high_i;
            units_q_o <= units_i;
            len_q_o   <= len_i;
        end
    end

    // Capture the sign (units flag) and the old high-order digit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            neg_q_o       <= 1'b0;
            top_digit_q_o <= 4'd0;
        end else begin
            if (state_i == S_RD_SRC && first_idx) begin
                neg_q_o <= rdata_i.flag;
            end
            if (state_i == S_WR_DST && first_idx) begin
                top_digit_q_o <= rdata_i.digit;
            end
        end
    end

endmodule

// File: rtl/dshift_seq.sv
// Module: sequencer. Steps through the sign read, the high-to-low copy, the
// source flag clear and the ascending zero fill. Produces the digit index,
// the fill offset and the one-cycle done pulse.
// Assumes len >= 2; the copy loop ends at index len-1.
module dshift_seq
    import dshift_pkg::*;
#(
    parameter int AW = 10,
    parameter int LW = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [LW-1:0] len_q_i,
    input  logic          rd_flag_i,
    output state_t        state_o,
    output logic [LW-1:0] idx_o,
    output logic [AW-1:0] off_o,
    output logic          done_o
);

    logic last_idx;
    logic first_idx;
    assign last_idx  = (idx_o == len_q_i - LW'(1));
    assign first_idx = (idx_o == '0);

    // State, counters and done pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_o <= S_IDLE;
            idx_o   <= '0;
            off_o   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_o)
                S_IDLE: begin
                    if (start_i) begin
                        state_o <= S_RD_SIGN;
                        idx_o   <= '0;
                        off_o   <= '0;
                    end
                end
                S_RD_SIGN: state_o <= S_RD_SRC;
                S_RD_SRC:  state_o <= S_WR_DST;
                S_WR_DST: begin
                    if (first_idx) begin
                        state_o <= S_CLR_SRC;
                    end else if (last_idx) begin
                        state_o <= S_FILL_ZERO;
                    end else begin
                        idx_o   <= idx_o + LW'(1);
                        state_o <= S_RD_SRC;
                    end
                end
                S_CLR_SRC: begin
                    if (last_idx) begin
                        state_o <= S_FILL_ZERO;
                    end else begin
                        idx_o   <= idx_o + LW'(1);
                        state_o <= S_RD_SRC;
                    end
                end
                S_FILL_ZERO: state_o <= S_FILL_RD;
                S_FILL_RD:   state_o <= S_FILL_EVAL;
                S_FILL_EVAL: begin
                    if (rd_flag_i) begin
                        state_o <= S_IDLE;
                        done_o  <= 1'b1;
                    end else begin
                        off_o   <= off_o + AW'(1);
                        state_o <= S_FILL_RD;
                    end
                end
                default: state_o <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dshift_membus.sv
// Module: memory bus former. Combinational. Turns the sequencer state and the
// held operands into one memory access per cycle.
// Assumes read data for the previous cycle's read is on rdata_i.
module dshift_membus
    import dshift_pkg::*;
#(
    parameter int AW = 10,
    parameter int LW = 6
) (
    input  state_t        state_i,
    input  logic [LW-1:0] idx_i,
    input  logic [AW-1:0] off_i,
    input  logic [AW-1:0] high_q_i,
    input  logic [AW-1:0] units_q_i,
    input  logic [LW-1:0] len_q_i,
    input  logic          neg_q_i,
    input  logic [3:0]    top_digit_q_i,
    input  dword_t        rdata_i,
    output logic          en_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output dword_t        wdata_o
);

    logic [AW-1:0] len_ext;
    logic [AW-1:0] idx_ext;
    logic [AW-1:0] src_base;
    logic [AW-1:0] fill_base;
    logic [AW-1:0] probe_addr;

    assign len_ext    = AW'(len_q_i);
    assign idx_ext    = AW'(idx_i);
    assign src_base   = units_q_i - len_ext + AW'(1);
    assign fill_base  = high_q_i + len_ext;
    assign probe_addr = fill_base + off_i + AW'(1);

    // Select the single access for this cycle.
    always_comb begin
        en_o    = 1'b0;
        we_o    = 1'b0;
        addr_o  = '0;
        wdata_o = '0;
        case (state_i)
            S_RD_SIGN: begin
                en_o   = 1'b1;
                addr_o = units_q_i;
            end
            S_RD_SRC: begin
                en_o   = 1'b1;
                addr_o = src_base + idx_ext;
            end
            S_WR_DST: begin
                en_o          = 1'b1;
                we_o          = 1'b1;
                addr_o        = high_q_i + idx_ext;
                wdata_o.digit = rdata_i.digit;
                wdata_o.flag  = (idx_i == '0) ? rdata_i.flag : 1'b0;
            end
            S_CLR_SRC: begin
                en_o          = 1'b1;
                we_o          = 1'b1;
                addr_o        = src_base;
                wdata_o.digit = top_digit_q_i;
            end
            S_FILL_ZERO: begin
                en_o   = 1'b1;
                we_o   = 1'b1;
                addr_o = fill_base;
            end
            S_FILL_RD: begin
                en_o   = 1'b1;
                addr_o = probe_addr;
            end
            S_FILL_EVAL: begin
                addr_o = probe_addr;
                if (!rdata_i.flag) begin
                    en_o = 1'b1;
                    we_o = 1'b1;
                end else if (neg_q_i) begin
                    en_o         = 1'b1;
                    we_o         = 1'b1;
                    wdata_o.flag = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dshift_engine.sv
// Module: top of the decimal floating shift-left engine. Widens a flagged-BCD
// mantissa downward in memory: copies the high-to-low digits, then zero-fills
// upward until a flag, applying the sign rule at the stop.
// Assumes len >= 2, units - new_high + 1 > len, and a single-port memory
// with one-cycle read latency.
module dshift_engine
    import dshift_pkg::*;
#(
    parameter int AW = 10,
    parameter int LW = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [AW-1:0] new_high_i,
    input  logic [AW-1:0] units_i,
    input  logic [LW-1:0] len_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          mem_en_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [4:0]    mem_wdata_o,
    input  logic [4:0]    mem_rdata_i
);

    state_t        state;
    logic [LW-1:0] idx;
    logic [AW-1:0] off;
    logic [AW-1:0] high_q;
    logic [AW-1:0] units_q;
    logic [LW-1:0] len_q;
    logic          neg_q;
    logic [3:0]    top_digit_q;
    dword_t        rdata;
    dword_t        wdata;

    assign rdata       = dword_t'(mem_rdata_i);
    assign mem_wdata_o = wdata;
    assign busy_o      = (state != S_IDLE);

    dshift_seq #(.AW(AW), .LW(LW)) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .len_q_i   (len_q),
        .rd_flag_i (rdata.flag),
        .state_o   (state),
        .idx_o     (idx),
        .off_o     (off),
        .done_o    (done_o)
    );

    dshift_opnd #(.AW(AW), .LW(LW)) u_opnd (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .start_i       (start_i),
        .state_i       (state),
        .idx_i         (idx),
        .new_high_i    (new_high_i),
        .units_i       (units_i),
        .len_i         (len_i),
        .rdata_i       (rdata),
        .high_q_o      (high_q),
        .units_q_o     (units_q),
        .len_q_o       (len_q),
        .neg_q_o       (neg_q),
        .top_digit_q_o (top_digit_q)
    );

    dshift_membus #(.AW(AW), .LW(LW)) u_bus (
        .state_i       (state),
        .idx_i         (idx),
        .off_i         (off),
        .high_q_i      (high_q),
        .units_q_i     (units_q),
        .len_q_i       (len_q),
        .neg_q_i       (neg_q),
        .top_digit_q_i (top_digit_q),
        .rdata_i       (rdata),
        .en_o          (mem_en_o),
        .we_o          (mem_we_o),
        .addr_o        (mem_addr_o),
        .wdata_o       (wdata)
    );

endmodule

// File: rtl/dshift_engine_chk.sv
// Module: property checker for the shift-left engine, bound into the top.
// Assumes it sees the top's ports plus its held sign, operands and state.
module dshift_engine_chk
    import dshift_pkg::*;
#(
    parameter int AW = 10
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          busy_i,
    input logic          done_i,
    input logic          mem_en_i,
    input logic          mem_we_i,
    input logic [4:0]    mem_wdata_i,
    input logic [4:0]    mem_rdata_i,
    input logic          neg_i,
    input logic [AW-1:0] high_q_i,
    input state_t        state_i
);

    // R1: no memory traffic while idle.
    a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_i |-> !mem_en_i);

    // R11: a write is always an enabled access.
    a_r11_we_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_i |-> mem_en_i);

    // R9: done lasts one cycle.
    a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

    // R9: done follows the last busy cycle.
    a_r9_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> ($past(busy_i) && !busy_i));

    // R10: held operands do not move during a run.
    a_r10_operands_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && $past(busy_i)) |-> $stable(high_q_i));

    // R6: positive stop leaves the flagged word unwritten.
    a_r6_pos_stop_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == S_FILL_EVAL && mem_rdata_i[4] && !neg_i) |-> !mem_we_i);

    // R7: a flagged fill write occurs only for a negative fraction.
    a_r7_flag_write_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == S_FILL_EVAL && mem_we_i && mem_wdata_i[4]) |-> neg_i);

endmodule

bind dshift_engine dshift_engine_chk #(.AW(AW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_o),
    .done_i      (done_o),
    .mem_en_i    (mem_en_o),
    .mem_we_i    (mem_we_o),
    .mem_wdata_i (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .neg_i       (neg_q),
    .high_q_i    (high_q),
    .state_i     (state)
);

// File: tb/dshift_engine_tb_top.sv
// Bench: directed and seeded-random runs of the shift-left engine, each
// compared with a memory image and busy length computed by a bench model.
module dshift_engine_tb_top;

    localparam int AW     = 10;
    localparam int LW     = 6;
    localparam int DEPTH  = 1 << AW;
    localparam int CLK_NS = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] new_high = '0;
    logic [AW-1:0] units = '0;
    logic [LW-1:0] len = '0;
    logic          busy, done, mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [4:0]    mem_wdata;
    logic [4:0]    mem_rdata = '0;

    logic [4:0] mem  [DEPTH];
    logic [4:0] refm [DEPTH];

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_NS/2) clk = ~clk;

    dshift_engine #(.AW(AW), .LW(LW)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .new_high_i  (new_high),
        .units_i     (units),
        .len_i       (len),
        .busy_o      (busy),
        .done_o      (done),
        .mem_en_o    (mem_en),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata)
    );

    // Single-port memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bench model of one operation on refm; returns expected busy cycles.
    task automatic model_run(input int p, input int q, input int l, output int cyc);
        logic       sg;
        logic [4:0] w;
        int         x, k;
        sg = refm[q][4];
        for (int i = 0; i < l; i++) begin
            w = refm[q-l+1+i];
            refm[p+i] = {(i == 0) ? w[4] : 1'b0, w[3:0]};
            if (i == 0) refm[q-l+1] = {1'b0, w[3:0]};
        end
        x = p + l;
        refm[x] = 5'h00;
        k = 0;
        while (x < DEPTH - 2) begin
            k++;
            if (refm[x+1][4]) begin
                if (sg) refm[x+1] = 5'h10;
                break;
            end
            x++;
            refm[x] = 5'h00;
        end
        cyc = 3 + 2*l + 2*k;
    endtask

    // Fresh no-flag digits over a window.
    task automatic clean_window(input int lo, input int hi);
        for (int a = lo; a <= hi; a++) mem[a] = 5'($urandom % 10);
    endtask

    // Run one operation, optionally with a restart pulse mid-run (R10).
    task automatic run_op(input int p, input int q, input int l, input bit restart,
                          input string tag, output int busy_cycles);
        int exp_cyc, cyc, bad, first_bad;
        for (int a = 0; a < DEPTH; a++) refm[a] = mem[a];
        model_run(p, q, l, exp_cyc);
        @(negedge clk);
        new_high = AW'(p); units = AW'(q); len = LW'(l); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 4000) begin
            cyc++;
            if (restart && cyc == 4) begin
                new_high = AW'(p + 1); units = AW'(q + 3); len = LW'(l + 1); start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        busy_cycles = cyc;
        check(cyc == exp_cyc, {"R9 busy length ", tag}, cyc, exp_cyc);
        check(done == 1'b1, {"R9 done pulse ", tag}, done, 1);
        @(negedge clk);
        check(done == 1'b0, {"R9 done drop ", tag}, done, 0);
        bad = 0; first_bad = -1;
        for (int a = 0; a < DEPTH; a++) begin
            if (mem[a] !== refm[a]) begin
                bad++;
                if (first_bad < 0) first_bad = a;
            end
        end
        if (bad != 0)
            $display("  at addr %0d mem=%h model=%h", first_bad, mem[first_bad], refm[first_bad]);
        check(bad == 0, {"R2/R3/R4/R5/R6/R7/R8 image ", tag}, bad, 0);
    endtask

    int bc;

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_NS * 150000);
        n_checks++; n_fail++;
        $display("FAIL R9 watchdog expired actual=hang expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int a = 0; a < DEPTH; a++) mem[a] = 5'($urandom % 10);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(done == 1'b0, "R1 reset done", done, 0);
        check(mem_en == 1'b0, "R1 reset mem_en", mem_en, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: positive, stray flag inside the widened area (R8).
        clean_window(585, 610);
        mem[598][4] = 1'b1; mem[602][4] = 1'b1; mem[596][4] = 1'b1;
        run_op(590, 601, 4, 1'b0, "stray", bc);
        check(bc == 15, "R8 early stop length", bc, 15);
        check(mem[595] == 5'h00, "R5 zero before stray", mem[595], 0);
        check(mem[596][4] == 1'b1, "R6/R8 stray flag kept", mem[596], 16);
        check(mem[590][4] == 1'b1, "R3 field flag moved", mem[590], 16);
        check(mem[598][4] == 1'b0, "R4 source flag cleared", mem[598], 0);

        // Directed: clean positive field, stops at exponent flag.
        clean_window(585, 610);
        mem[598][4] = 1'b1; mem[602][4] = 1'b1;
        run_op(590, 601, 4, 1'b0, "clean pos", bc);
        check(bc == 27, "R9 clean positive length", bc, 27);
        check(mem[601] == 5'h00, "R5 units zeroed", mem[601], 0);
        check(mem[602][4] == 1'b1, "R6 exponent untouched", mem[602], 16);

        // Directed: negative field, flagged zero at units.
        clean_window(585, 610);
        mem[598][4] = 1'b1; mem[601][4] = 1'b1; mem[602][4] = 1'b1;
        run_op(590, 601, 4, 1'b0, "neg", bc);
        check(bc == 25, "R7 negative length", bc, 25);
        check(mem[601] == 5'h10, "R7 negative zero", mem[601], 16);

        // Directed: stray flag on first (untested) fill position.
        clean_window(585, 610);
        mem[598][4] = 1'b1; mem[602][4] = 1'b1; mem[594][4] = 1'b1;
        run_op(590, 601, 4, 1'b0, "first fill", bc);
        check(bc == 27, "R5 first fill not tested", bc, 27);

        // Directed: one-digit widening, overlapping fields.
        clean_window(95, 110);
        mem[101][4] = 1'b1; mem[104][4] = 1'b1;
        run_op(100, 103, 3, 1'b0, "overlap", bc);
        check(bc == 11, "R2 overlap length", bc, 11);

        // Directed: restart pulse while busy (R10).
        clean_window(295, 330);
        mem[310][4] = 1'b1; mem[316][4] = 1'b1;
        run_op(300, 315, 6, 1'b1, "R10 restart", bc);

        // Seeded random runs.
        for (int t = 0; t < 40; t++) begin
            int l, lp, p, q;
            l  = 2 + int'($urandom % 9);
            lp = 1 + int'($urandom % 12);
            p  = 20 + int'($urandom % 800);
            q  = p + l + lp - 1;
            clean_window(p - 2, q + 3);
            if ($urandom % 4 != 0) mem[q-l+1][4] = 1'b1;
            if ($urandom % 2 != 0) mem[q][4] = 1'b1;
            mem[q+1][4] = 1'b1;
            if ($urandom % 3 == 0) mem[p + l + int'($urandom % (q - p - l + 1))][4] = 1'b1;
            run_op(p, q, l, ($urandom % 5) == 0, "random", bc);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule